// File: doc/BRIEF.md
# Touch Digitizer Serial Link Controller

This block is the host-side engine of a synchronous serial link to a touch-screen successive-approximation converter. A requester hands it a 7-bit command through a valid/ready port. The block pulls chip select low and generates the serial clock by dividing the system clock. It shifts out an 8-bit command word whose first bit is always a start bit, waits for the converter to flag BUSY, and then clocks twelve conversion periods while it shifts the result in. The result is 8 or 12 bits, chosen by one command bit.

The converter uses the serial clock as its conversion clock. For this reason the controller keeps clocking for all twelve conversion periods even when only eight result bits are wanted. It then releases chip select and presents the result right-aligned on a 12-bit output, together with a one-cycle valid pulse. After that it keeps chip select high for one full serial clock period before it accepts the next request. When the serial clock rate implied by the system clock and the divider falls outside 10 kHz to 2 MHz, elaboration stops with an error.

Top module: `tsadc_link_ctrl`

## Requirements
- R1: After reset, cs_n is 1, dclk is 0, din is 0, req_ready is 1 and res_valid is 0.
- R2: While cs_n is 0, every high phase and every low phase of dclk after the first falling edge lasts exactly HALF_DIV system cycles. dclk is 0 whenever cs_n is 1.
- R3: The converter receives on its first 8 rising dclk edges the word {1, req_cmd[6:0]}, MSB first. din changes only together with a falling dclk edge or with the cycle that starts the transaction, so it is stable across every rising edge.
- R4: From the 9th rising edge on, busy is sampled on each rising edge. The first result bit is taken on the rising edge after the one where busy is seen high.
- R5: Exactly 12 rising edges follow the edge that ended the busy wait, in both resolutions. cs_n then rises together with the next falling edge.
- R6: req_cmd[3] = 1 selects 8-bit mode: 8 bits are captured into res_data[7:0] and res_data[11:8] is 0. req_cmd[3] = 0 captures 12 bits.
- R7: Result bits are shifted in MSB first as a plain binary code. res_valid is a one-cycle pulse in exactly the cycle in which cs_n returns to 1.
- R8: If busy is not seen high within BUSY_WAIT rising edges (default 4), the controller acts as if busy were seen on the last of them, and the conversion periods start from there.
- R9: dout and busy have no effect while cs_n is 1. dout has no effect during the command phase, and busy has no effect outside the busy wait.
- R10: req_ready is 1 only while idle. A request made during a transaction is held off, not lost, and is accepted later. req_ready returns to 1 exactly 2*HALF_DIV cycles after cs_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, held until accepted |
| req_ready | output | 1 | Controller idle and able to accept |
| req_cmd | input | 7 | Command bits sent after the start bit; bit 3 selects 8-bit mode |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Right-aligned conversion result |
| cs_n | output | 1 | Chip select to the converter, active low |
| dclk | output | 1 | Serial/conversion clock to the converter |
| din | output | 1 | Serial command data to the converter |
| dout | input | 1 | Serial result data from the converter |
| busy | input | 1 | Converter conversion flag |

## Verification
Two events can land on the same serial clock edge. BUSY can arrive on the very edge where the wait limit expires, and a queued request can be waiting on the cycle where the result strobe fires and chip select rises. The bench sets the converter model's BUSY delay to BUSY_WAIT-1, so both exits of the wait happen together, and checks that the capture still lines up with the first data bit. It also holds a second request high throughout a running transaction and checks that the request is not accepted before the gap has elapsed and then starts a fresh transaction. The expected results come from a bench function that maps each capture edge to the bit the model drove.

// File: rtl/tsadc_link_pkg.sv
package tsadc_link_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_BUSYW,
        ST_CONV,
        ST_TAIL,
        ST_GAP
    } link_state_e;
endpackage

// File: rtl/tsadc_link_clkgen.sv
module tsadc_link_clkgen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic dclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } clk_st_t;

    clk_st_t cur_q, nxt_d;
    logic    wrap;

    always_comb begin
        nxt_d = cur_q;
        wrap  = (cur_q.cnt == CW'(HALF_DIV - 1));
        if (!run) begin
            nxt_d = '0;
        end else if (wrap) begin
            nxt_d.cnt = '0;
            nxt_d.lvl = !cur_q.lvl;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // Ticks mark the cycle whose closing edge flips dclk.
    assign rise_tick = run && wrap && !cur_q.lvl;
    assign fall_tick = run && wrap && cur_q.lvl;
    assign dclk      = cur_q.lvl;
endmodule

// File: rtl/tsadc_link_shift.sv
module tsadc_link_shift #(
    parameter int CMD_W = 8,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] load_word,
    input  logic             tx_shift,
    input  logic             rx_clear,
    input  logic             rx_en,
    input  logic             rx_bit,
    output logic             tx_bit,
    output logic [RES_W-1:0] rx_word
);
    typedef struct packed {
        logic [CMD_W-1:0] tx;
        logic [RES_W-1:0] rx;
    } sh_st_t;

    sh_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load)          nxt_d.tx = load_word;
        else if (tx_shift) nxt_d.tx = {cur_q.tx[CMD_W-2:0], 1'b0};
        if (rx_clear)      nxt_d.rx = '0;
        else if (rx_en)    nxt_d.rx = {cur_q.rx[RES_W-2:0], rx_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tx_bit  = cur_q.tx[CMD_W-1];
    assign rx_word = cur_q.rx;
endmodule

// File: rtl/tsadc_link_ctrl.sv
module tsadc_link_ctrl
    import tsadc_link_pkg::*;
#(
    parameter int SYS_CLK_HZ   = 100_000_000,
    parameter int HALF_DIV     = 25,
    parameter int CMD_W        = 8,
    parameter int RES_W        = 12,
    parameter int LOW_RES_W    = 8,
    parameter int CONV_PERIODS = 12,
    parameter int BUSY_WAIT    = 4,
    parameter int MODE_BIT     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CMD_W-2:0] req_cmd,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             cs_n,
    output logic             dclk,
    output logic             din,
    input  logic             dout,
    input  logic             busy
);
    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int DCLK_HZ = SYS_CLK_HZ / (2 * HALF_DIV);
    localparam int M1      = (CMD_W > CONV_PERIODS) ? CMD_W : CONV_PERIODS;
    localparam int M2      = (M1 > BUSY_WAIT) ? M1 : BUSY_WAIT;
    localparam int CNT_MAX = (M2 > GAP_CYC) ? M2 : GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    generate
        if (DCLK_HZ > 2_000_000 || DCLK_HZ < 10_000) begin : g_rate_bad
            $error("serial clock rate outside 10 kHz .. 2 MHz");
        end
        if (RES_W > CONV_PERIODS || LOW_RES_W > RES_W) begin : g_width_bad
            $error("result width exceeds conversion periods");
        end
    endgenerate

    typedef struct packed {
        link_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             cs_n;
        logic             mode8;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{state: ST_IDLE, cnt: '0, cs_n: 1'b1,
                                 mode8: 1'b0, done: 1'b0};

    ctl_t cur_q, nxt_d;
    logic run_clk, rise_tick, fall_tick;
    logic load, tx_shift, rx_clear, rx_en;
    logic [CNT_W-1:0] nbits;
    logic mode8_q;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.done = 1'b0;
        load     = 1'b0;
        tx_shift = 1'b0;
        rx_clear = 1'b0;
        rx_en    = 1'b0;
        run_clk  = (cur_q.state == ST_CMD) || (cur_q.state == ST_BUSYW) ||
                   (cur_q.state == ST_CONV) || (cur_q.state == ST_TAIL);
        nbits    = cur_q.mode8 ? CNT_W'(LOW_RES_W) : CNT_W'(RES_W);
        case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.state = ST_CMD;
                    nxt_d.cs_n  = 1'b0;
                    nxt_d.cnt   = '0;
                    nxt_d.mode8 = req_cmd[MODE_BIT];
                    load        = 1'b1;
                    rx_clear    = 1'b1;
                end
            end
            ST_CMD: begin
                if (fall_tick) begin
                    tx_shift = 1'b1;
                    if (cur_q.cnt == CNT_W'(CMD_W - 1)) begin
                        nxt_d.state = ST_BUSYW;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_BUSYW: begin
                if (rise_tick) begin
                    if (busy || cur_q.cnt == CNT_W'(BUSY_WAIT - 1)) begin
                        nxt_d.state = ST_CONV;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (rise_tick) begin
                    rx_en = (cur_q.cnt < nbits);
                    if (cur_q.cnt == CNT_W'(CONV_PERIODS - 1)) begin
                        nxt_d.state = ST_TAIL;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (fall_tick) begin
                    nxt_d.state = ST_GAP;
                    nxt_d.cs_n  = 1'b1;
                    nxt_d.done  = 1'b1;
                    nxt_d.cnt   = '0;
                end
            end
            ST_GAP: begin
                if (cur_q.cnt == CNT_W'(GAP_CYC - 1)) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: nxt_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= CTL_RST;
        else        cur_q <= nxt_d;
    end

    tsadc_link_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_clk),
        .dclk      (dclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    tsadc_link_shift #(.CMD_W(CMD_W), .RES_W(RES_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word ({1'b1, req_cmd}),
        .tx_shift  (tx_shift),
        .rx_clear  (rx_clear),
        .rx_en     (rx_en),
        .rx_bit    (dout),
        .tx_bit    (din),
        .rx_word   (res_data)
    );

    assign req_ready = (cur_q.state == ST_IDLE);
    assign res_valid = cur_q.done;
    assign cs_n      = cur_q.cs_n;
    assign mode8_q   = cur_q.mode8;
endmodule

// File: rtl/tsadc_link_chk.sv
module tsadc_link_chk #(
    parameter int HALF_DIV  = 25,
    parameter int RES_W     = 12,
    parameter int LOW_RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             dclk,
    input logic             din,
    input logic             req_valid,
    input logic             req_ready,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data,
    input logic             mode8
);
    logic last_q;
    logic had_fall_q;
    int   plen_q;

    // Run length of the current dclk level, ending at the previous sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q     <= 1'b0;
            plen_q     <= 1;
            had_fall_q <= 1'b0;
        end else begin
            last_q <= dclk;
            plen_q <= (dclk != last_q) ? 1 : plen_q + 1;
            if (cs_n)                  had_fall_q <= 1'b0;
            else if (last_q && !dclk)  had_fall_q <= 1'b1;
        end
    end

    assert_dclk_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dclk);

    assert_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q && !dclk) |-> (plen_q == HALF_DIV));

    assert_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_q && dclk && had_fall_q) |-> (plen_q == HALF_DIV));

    assert_din_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(dclk)) |-> $stable(din));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mode8) |-> (res_data[RES_W-1:LOW_RES_W] == '0));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_valid_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> res_valid);

    assert_release_at_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(cs_n));

    assert_ready_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);

    assert_start_needs_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(req_valid && req_ready));
endmodule

bind tsadc_link_ctrl tsadc_link_chk #(
    .HALF_DIV  (HALF_DIV),
    .RES_W     (RES_W),
    .LOW_RES_W (LOW_RES_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .dclk      (dclk),
    .din       (din),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .mode8     (mode8_q)
);

// File: tb/tsadc_link_ctrl_tb_top.sv
module tsadc_link_ctrl_tb_top;
    localparam int H = 25;
    localparam int W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_cmd = '0;
    logic        res_valid;
    logic [11:0] res_data;
    logic        cs_n, dclk, din;
    logic        dout_w, busy_w;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // converter model state
    logic        dev_dout = 1'b0, dev_busy = 1'b0;
    logic        noise_en = 1'b0, n_dout = 1'b0, n_busy = 1'b0;
    logic [11:0] dev_data = '0;
    int          dev_dly = 0;
    bit          dev_nobusy = 1'b0;
    int          fcnt = 0, rcnt = 0;
    logic [7:0]  cmd_seen = '0;
    logic        cs_prev = 1'b1, dclk_prev = 1'b0;

    // monitor for high-phase lengths
    int hl = 0, hmin = 0, hmax = 0;
    logic mon_prev = 1'b0;

    assign dout_w = noise_en ? n_dout : dev_dout;
    assign busy_w = noise_en ? n_busy : dev_busy;

    always #5 clk = ~clk;

    tsadc_link_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .res_valid(res_valid), .res_data(res_data),
        .cs_n(cs_n), .dclk(dclk), .din(din), .dout(dout_w), .busy(busy_w)
    );

    always @(cs_n, dclk) begin
        if (cs_n != cs_prev) begin
            if (!cs_n) begin
                fcnt = 0; rcnt = 0; cmd_seen = '0;
                dev_busy = 1'b0; dev_dout = 1'($urandom);
            end else begin
                dev_dout = 1'($urandom); dev_busy = 1'($urandom);
            end
        end else if (!cs_n && dclk != dclk_prev) begin
            if (dclk) begin
                rcnt = rcnt + 1;
                if (rcnt <= 8) cmd_seen = {cmd_seen[6:0], din};
            end else begin
                fcnt = fcnt + 1;
                if (fcnt < 8) begin
                    dev_dout = 1'($urandom); dev_busy = 1'($urandom);
                end else begin
                    int i;
                    dev_busy = !dev_nobusy && (fcnt == 8 + dev_dly);
                    i = fcnt - 9 - dev_dly;
                    dev_dout = (i >= 0 && i < 12) ? dev_data[11-i] : 1'b0;
                end
            end
        end
        cs_prev = cs_n; dclk_prev = dclk;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (dclk) hl = hl + 1;
        else if (mon_prev) begin
            if (hmin == 0 || hl < hmin) hmin = hl;
            if (hl > hmax) hmax = hl;
            hl = 0;
        end
        mon_prev = dclk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int busy_edge(input int dly, input bit nob);
        if (nob) return 8 + W;
        return 9 + ((dly < W - 1) ? dly : W - 1);
    endfunction

    function automatic logic [11:0] exp_res(input logic [11:0] data, input int dly,
                                            input bit nob, input bit m8);
        logic [11:0] v = '0;
        int r = busy_edge(dly, nob);
        int n = m8 ? 8 : 12;
        for (int j = 0; j < n; j++) begin
            int i = r + 1 + j - 10 - dly;
            v = {v[10:0], (i >= 0 && i < 12) ? data[11-i] : 1'b0};
        end
        return v;
    endfunction

    task automatic issue(input logic [6:0] cmd);
        @(negedge clk);
        req_cmd = cmd; req_valid = 1'b1;
    endtask

    task automatic wait_accept();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(cs_n == 1'b0, "R10", "cs_n after accept", cs_n, 0);
        hmin = 0; hmax = 0;
    endtask

    task automatic collect(input logic [6:0] cmd, input logic [11:0] data,
                           input int dly, input bit nob);
        int n = 0;
        logic [11:0] e;
        while (!res_valid && n < 5000) begin @(negedge clk); n++; end
        chk(res_valid, "R7", "result strobe seen", res_valid, 1);
        e = exp_res(data, dly, nob, cmd[3]);
        chk(res_data == e, cmd[3] ? "R6" : "R7", "result", res_data, e);
        chk(cmd_seen == {1'b1, cmd}, "R3", "command seen", cmd_seen, {1'b1, cmd});
        chk(rcnt == busy_edge(dly, nob) + 12, nob ? "R8" : "R5", "rising edges",
            rcnt, busy_edge(dly, nob) + 12);
        chk(cs_n == 1'b1, "R7", "cs_n at strobe", cs_n, 1);
        chk(hmin == H && hmax == H, "R2", "high phase", hmax, H);
        n = 0;
        @(negedge clk); n++;
        chk(!res_valid, "R7", "strobe width", res_valid, 0);
        while (!req_ready && n < 1000) begin @(negedge clk); n++; end
        chk(n == 2 * H, "R10", "gap to ready", n, 2 * H);
    endtask

    task automatic txn(input logic [6:0] cmd, input logic [11:0] data,
                       input int dly, input bit nob);
        dev_data = data; dev_dly = dly; dev_nobusy = nob;
        issue(cmd);
        wait_accept();
        collect(cmd, data, dly, nob);
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(negedge clk);
        chk(1'b0, "WDOG", "run timed out", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        logic [11:0] keep;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        chk(cs_n && !dclk && !din && req_ready && !res_valid, "R1", "in reset",
            {cs_n, dclk, din, req_ready, res_valid}, 5'b10010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !dclk && !din && req_ready && !res_valid, "R1", "after reset",
            {cs_n, dclk, din, req_ready, res_valid}, 5'b10010);

        // directed corners
        txn(7'h51, 12'hA5C, 0, 1'b0);             // R4 12-bit
        txn(7'h08, 12'hFFF, 0, 1'b0);             // R6 8-bit all ones
        txn(7'h7F, 12'h000, 1, 1'b0);             // R6 zero, delayed busy
        txn(7'h00, 12'h9C3, W - 1, 1'b0);         // R4 busy on wait limit
        txn(7'h22, 12'hB6D, 0, 1'b1);             // R8 no busy, 12-bit
        txn(7'h2A, 12'hB6D, 0, 1'b1);             // R8 no busy, 8-bit

        // R9: noise on dout/busy while idle
        keep = res_data;
        noise_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            n_dout = 1'($urandom); n_busy = 1'($urandom);
            @(negedge clk);
            if (k == 39)
                chk(cs_n && !dclk && !din && !res_valid && res_data == keep, "R9",
                    "idle inputs ignored", res_data, keep);
        end
        noise_en = 1'b0;

        // R10: request held during a transaction
        dev_data = 12'h3E1; dev_dly = 0; dev_nobusy = 1'b0;
        issue(7'h15);
        wait_accept();
        repeat (200) @(negedge clk);
        req_cmd = 7'h4C; req_valid = 1'b1;
        @(negedge clk);
        chk(!req_ready && !cs_n, "R10", "held off while busy", req_ready, 0);
        req_cmd = 7'h15;
        collect(7'h15, 12'h3E1, 0, 1'b0);
        req_cmd = 7'h4C;
        wait_accept();
        collect(7'h4C, 12'h3E1, 0, 1'b0);

        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [6:0]  c = 7'($urandom);
            logic [11:0] d = 12'($urandom);
            bit nb = ($urandom % 6) == 0;
            int dl = nb ? 0 : int'($urandom % W);
            txn(c, d, dl, nb);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule